// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for a system with 1 KB pages. It does this by reading two page-table entries from memory. A requester hands over the virtual address together with the current page-table base, which is the byte address of the outer table. The walker then makes the two reads, one after the other, through a single read port that uses request and acknowledge.

The virtual address is split into three fields. Bits 31:20 are a 12-bit outer index, bits 19:10 are a 10-bit inner index and bits 9:0 are the page offset. Each table entry is 4 bytes, so an entry's address is the table base plus four times its index. In every entry, bit 0 is the valid flag and bits 31:10 hold a frame number. In an outer entry that frame is where the inner table lives. In an inner entry it is the data page.

The walk ends in one of two ways:
- **Success:** the walker presents the frame joined with the unchanged offset.
- **Page fault:** it stops at the first invalid entry and reports a fault, marking whether the outer or the inner level held that entry.

The walker is a five-state machine:

| State | Action | Leaves on | Next state |
|---|---|---|---|
| IDLE | ready for a request | accept | READ_OUTER |
| READ_OUTER | reads the outer entry | outer_ok | READ_INNER |
| | | outer_bad | FAULT |
| READ_INNER | reads the inner entry | inner_ok | DONE |
| | | inner_bad | FAULT |
| DONE | reports the physical address | retire (one cycle) | IDLE |
| FAULT | reports the fault | retire (one cycle) | IDLE |

Top module: `twolevel_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_req`, `done_valid` and `fault_valid` are 0.
- R2: A request is taken only while `req_ready` is 1 (IDLE). A `req_valid` pulse raised during a walk has no effect on that walk's reads or result.
- R3: The first read targets `base_reg + 4*vaddr[31:20]`. Both `base_reg` and the virtual address are captured on the accepting edge.
- R4: After a valid outer entry E, the second read targets `{E[31:10], 10'b0} + 4*vaddr[19:10]`.
- R5: `mem_req` stays high with `mem_addr` unchanged until `mem_ack`, however many cycles that takes.
- R6: An entry is valid when bit 0 is 1. Entry bits 9:1 affect neither the read addresses nor the result.
- R7: An invalid outer entry ends the walk in FAULT with `fault_level` 0, and no second read is made.
- R8: An invalid inner entry ends the walk in FAULT with `fault_level` 1.
- R9: A valid inner entry I gives `done_valid` with `done_paddr = {I[31:10], vaddr[9:0]}`.
- R10: `done_valid` and `fault_valid` are never high together. Each lasts exactly one cycle, and `req_ready` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request to translate `req_vaddr` |
| req_vaddr | input | 32 | Virtual address to translate |
| base_reg | input | 32 | Byte address of the outer table |
| req_ready | output | 1 | High in IDLE; a request is taken then |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ack | input | 1 | Read data valid on `mem_rdata` |
| mem_rdata | input | 32 | Entry returned by memory |
| done_valid | output | 1 | One-cycle pulse: translation succeeded |
| done_paddr | output | 32 | Physical address, valid with `done_valid` |
| fault_valid | output | 1 | One-cycle pulse: page fault |
| fault_level | output | 1 | 0 = outer entry invalid, 1 = inner entry invalid |

## Verification
The bench builds the walker with its default split of 32-bit addresses, 10-bit offset and 10-bit inner index. This makes the outer index 12 bits. With these values the all-ones corner is reachable: outer index 0xFFF, inner index 0x3FF and offset 0x3FF, with no carry lost in the entry address sums. A memory model with an adjustable acknowledge delay covers zero-wait and multi-cycle reads. It also covers faults at each level, junk in entry bits 9:1, and a request raised while a walk is in flight.

// File: rtl/walk_pkg.sv
package walk_pkg;

    // Walk controller states
    typedef enum logic [2:0] {
        WS_IDLE       = 3'd0,
        WS_READ_OUTER = 3'd1,
        WS_READ_INNER = 3'd2,
        WS_DONE       = 3'd3,
        WS_FAULT      = 3'd4
    } walk_state_e;

    // Which table level produced a fault
    typedef enum logic {
        LVL_OUTER = 1'b0,
        LVL_INNER = 1'b1
    } walk_level_e;

endpackage

// File: rtl/walk_entry_addr.sv
// Entry address of one table level: table base plus index scaled by entry size.
module walk_entry_addr #(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 10,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int PAD_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] index_wide;

    always_comb begin
        index_wide = {{PAD_W{1'b0}}, index};
        entry_addr = table_base + (index_wide << ENTRY_SHIFT);
    end
endmodule

// File: rtl/walk_pte_decode.sv
// Splits a table entry into its valid flag and its frame number.
module walk_pte_decode #(
    parameter int PTE_W   = 32,
    parameter int OFF_W   = 10,
    parameter int FRAME_W = PTE_W - OFF_W
) (
    input  logic [PTE_W-1:0]   pte,
    output logic               pte_valid,
    output logic [FRAME_W-1:0] pte_frame
);
    always_comb begin
        pte_valid = pte[0];
        pte_frame = pte[PTE_W-1:OFF_W];
    end
endmodule

// File: rtl/walk_fsm.sv
// Walk controller: state register plus one output/next-state process.
module walk_fsm
    import walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_ack,
    input  logic        pte_valid,
    output walk_state_e state,
    output logic        accept,
    output logic        outer_ok,
    output logic        outer_bad,
    output logic        inner_ok,
    output logic        inner_bad,
    output logic        sel_inner,
    output logic        req_ready,
    output logic        mem_req,
    output logic        done_valid,
    output logic        fault_valid
);
    walk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        accept      = 1'b0;
        outer_ok    = 1'b0;
        outer_bad   = 1'b0;
        inner_ok    = 1'b0;
        inner_bad   = 1'b0;
        sel_inner   = 1'b0;
        req_ready   = 1'b0;
        mem_req     = 1'b0;
        done_valid  = 1'b0;
        fault_valid = 1'b0;
        unique case (state_q)
            WS_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = WS_READ_OUTER;
                end
            end
            WS_READ_OUTER: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    if (pte_valid) begin
                        outer_ok = 1'b1;
                        state_d  = WS_READ_INNER;
                    end else begin
                        outer_bad = 1'b1;
                        state_d   = WS_FAULT;
                    end
                end
            end
            WS_READ_INNER: begin
                mem_req   = 1'b1;
                sel_inner = 1'b1;
                if (mem_ack) begin
                    if (pte_valid) begin
                        inner_ok = 1'b1;
                        state_d  = WS_DONE;
                    end else begin
                        inner_bad = 1'b1;
                        state_d   = WS_FAULT;
                    end
                end
            end
            WS_DONE: begin
                done_valid = 1'b1;
                state_d    = WS_IDLE;
            end
            WS_FAULT: begin
                fault_valid = 1'b1;
                state_d     = WS_IDLE;
            end
            default: state_d = WS_IDLE;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/twolevel_walker.sv
// Two-level page table walker, 1 KB pages, 12/10/10 address split by default.
module twolevel_walker
    import walk_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 10,
    parameter int INNER_W     = 10,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] base_reg,
    output logic              req_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_paddr,
    output logic              fault_valid,
    output logic              fault_level
);
    localparam int OUTER_W  = ADDR_W - OFF_W - INNER_W;
    localparam int FRAME_W  = ADDR_W - OFF_W;
    localparam int INNER_LO = OFF_W;
    localparam int OUTER_LO = OFF_W + INNER_W;

    // Captured request and walk progress
    logic [ADDR_W-1:0]  va_q;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  inner_tbl_q;
    logic [FRAME_W-1:0] frame_q;
    walk_level_e        level_q;

    // Controller handshakes
    walk_state_e state;
    logic        accept, outer_ok, outer_bad, inner_ok, inner_bad, sel_inner;

    // Decoded entry
    logic               pte_valid;
    logic [FRAME_W-1:0] pte_frame;

    // Candidate read addresses
    logic [ADDR_W-1:0] outer_addr, inner_addr;

    walk_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .mem_ack     (mem_ack),
        .pte_valid   (pte_valid),
        .state       (state),
        .accept      (accept),
        .outer_ok    (outer_ok),
        .outer_bad   (outer_bad),
        .inner_ok    (inner_ok),
        .inner_bad   (inner_bad),
        .sel_inner   (sel_inner),
        .req_ready   (req_ready),
        .mem_req     (mem_req),
        .done_valid  (done_valid),
        .fault_valid (fault_valid)
    );

    walk_pte_decode #(
        .PTE_W (ADDR_W),
        .OFF_W (OFF_W)
    ) u_dec (
        .pte       (mem_rdata),
        .pte_valid (pte_valid),
        .pte_frame (pte_frame)
    );

    walk_entry_addr #(
        .ADDR_W      (ADDR_W),
        .IDX_W       (OUTER_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_outer_addr (
        .table_base (base_q),
        .index      (va_q[ADDR_W-1:OUTER_LO]),
        .entry_addr (outer_addr)
    );

    walk_entry_addr #(
        .ADDR_W      (ADDR_W),
        .IDX_W       (INNER_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_inner_addr (
        .table_base (inner_tbl_q),
        .index      (va_q[OUTER_LO-1:INNER_LO]),
        .entry_addr (inner_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q        <= '0;
            base_q      <= '0;
            inner_tbl_q <= '0;
            frame_q     <= '0;
            level_q     <= LVL_OUTER;
        end else begin
            if (accept) begin
                va_q   <= req_vaddr;
                base_q <= base_reg;
            end
            if (outer_ok)  inner_tbl_q <= {pte_frame, {OFF_W{1'b0}}};
            if (inner_ok)  frame_q     <= pte_frame;
            if (outer_bad) level_q     <= LVL_OUTER;
            if (inner_bad) level_q     <= LVL_INNER;
        end
    end

    always_comb begin
        mem_addr    = sel_inner ? inner_addr : outer_addr;
        done_paddr  = {frame_q, va_q[OFF_W-1:0]};
        fault_level = level_q;
    end
endmodule

// File: rtl/walk_chk.sv
// Protocol and result checks attached to the walker.
module walk_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_rdata,
    input logic              done_valid,
    input logic              fault_valid
);
    // R5: a pending read keeps its request and address
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R2: no read while ready for a new request
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    // R10: results are exclusive
    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));

    // R10: result pulse lasts one cycle and is followed by ready
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |=> (req_ready && !done_valid && !fault_valid));

    // R9: success follows an acknowledged valid entry
    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_valid) |-> ($past(mem_ack) && $past(mem_rdata[0])));

    // R6: a fault follows an acknowledged invalid entry
    p_fault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_valid) |-> ($past(mem_ack) && !$past(mem_rdata[0])));
endmodule

bind twolevel_walker walk_chk #(.ADDR_W(ADDR_W)) u_walk_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .done_valid  (done_valid),
    .fault_valid (fault_valid)
);

// File: tb/twolevel_walker_tb_top.sv
`timescale 1ns/1ps
module twolevel_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] base_reg = '0;
    logic        req_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic        fault_valid;
    logic        fault_level;

    always #5 clk = ~clk;

    twolevel_walker dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_vaddr   (req_vaddr),
        .base_reg    (base_reg),
        .req_ready   (req_ready),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .done_valid  (done_valid),
        .done_paddr  (done_paddr),
        .fault_valid (fault_valid),
        .fault_level (fault_level)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // Sparse memory model; missing words read as 0 (invalid entry)
    logic [31:0] mem_tab [logic [31:0]];
    int          lat = 0;
    int          reads = 0;
    int          stable_err = 0;
    logic [31:0] seen [0:7];

    function automatic logic [31:0] lookup(input logic [31:0] a);
        if (mem_tab.exists(a)) return mem_tab[a];
        return 32'h0;
    endfunction

    initial begin : responder
        int          cnt;
        logic [31:0] first;
        cnt = 0;
        first = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                if (cnt == 0) first = mem_addr;
                else if (mem_addr != first) stable_err++;
                if (cnt >= lat) begin
                    mem_ack   = 1'b1;
                    mem_rdata = lookup(mem_addr);
                    if (reads < 8) seen[reads] = mem_addr;
                    reads++;
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Outcome of the last walk
    bit          w_done, w_fault, w_lvl;
    logic [31:0] w_paddr;

    task automatic wait_result();
        w_done = 0; w_fault = 0; w_lvl = 0; w_paddr = '0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done_valid || fault_valid) begin
                w_done  = done_valid;
                w_fault = fault_valid;
                w_lvl   = fault_level;
                w_paddr = done_paddr;
                break;
            end
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] base);
        @(negedge clk);
        reads = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        base_reg  = base;
        @(negedge clk);
        req_valid = 1'b0;
        base_reg  = 32'hDEAD_0000;
        req_vaddr = 32'hFFFF_FFFF;
        wait_result();
    endtask

    // Map va through base to a data frame, with junk bits 9:1 optional
    task automatic map(input logic [31:0] va, input logic [31:0] base,
                       input logic [21:0] tframe, input logic [21:0] dframe,
                       input logic [8:0] junk);
        mem_tab[base + {18'h0, va[31:20], 2'b00}] = {tframe, junk, 1'b1};
        mem_tab[{tframe, 10'h0} + {20'h0, va[19:10], 2'b00}] = {dframe, junk, 1'b1};
    endtask

    task automatic expect_ok(input string tag, input logic [31:0] va, input logic [31:0] base,
                             input logic [21:0] tframe, input logic [21:0] dframe);
        logic [31:0] a_out, a_in, pa;
        a_out = base + {18'h0, va[31:20], 2'b00};
        a_in  = {tframe, 10'h0} + {20'h0, va[19:10], 2'b00};
        pa    = {dframe, va[9:0]};
        chk(w_done && !w_fault, "R9", {tag, " done"}, {30'h0, w_done, w_fault}, 32'h2);
        chk(w_paddr == pa, "R9", {tag, " paddr"}, w_paddr, pa);
        chk(seen[0] == a_out, "R3", {tag, " outer addr"}, seen[0], a_out);
        chk(seen[1] == a_in, "R4", {tag, " inner addr"}, seen[1], a_in);
        @(negedge clk);
        chk(req_ready && !done_valid, "R10", {tag, " ready after"}, {31'h0, req_ready}, 32'h1);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "ready", {31'h0, req_ready}, 32'h1);
        chk(mem_req == 1'b0, "R1", "mem_req", {31'h0, mem_req}, 32'h0);
        chk(!done_valid && !fault_valid, "R1", "results", {30'h0, done_valid, fault_valid}, 32'h0);
    endtask

    task automatic t_basic();
        lat = 0;
        map(32'h1234_5678, 32'h0001_0000, 22'h00_0ABC, 22'h12_3456, 9'h0);
        walk(32'h1234_5678, 32'h0001_0000);
        expect_ok("zero wait", 32'h1234_5678, 32'h0001_0000, 22'h00_0ABC, 22'h12_3456);
    endtask

    task automatic t_slow();
        lat = 5;
        map(32'h0040_0C01, 32'h0002_0400, 22'h00_1000, 22'h3F_FFFF, 9'h0);
        walk(32'h0040_0C01, 32'h0002_0400);
        expect_ok("slow R5", 32'h0040_0C01, 32'h0002_0400, 22'h00_1000, 22'h3F_FFFF);
        chk(stable_err == 0, "R5", "addr stable while waiting", stable_err, 0);
    endtask

    task automatic t_corner();
        lat = 1;
        map(32'hFFFF_FFFF, 32'h0030_0000, 22'h05_5555, 22'h2A_AAAA, 9'h0);
        walk(32'hFFFF_FFFF, 32'h0030_0000);
        expect_ok("all-ones", 32'hFFFF_FFFF, 32'h0030_0000, 22'h05_5555, 22'h2A_AAAA);
    endtask

    task automatic t_junk_r6();
        lat = 2;
        map(32'h8000_0400, 32'h0004_0000, 22'h00_2222, 22'h00_3333, 9'h1FF);
        walk(32'h8000_0400, 32'h0004_0000);
        expect_ok("R6 junk bits", 32'h8000_0400, 32'h0004_0000, 22'h00_2222, 22'h00_3333);
    endtask

    task automatic t_outer_fault_r7();
        lat = 1;
        // outer entry with junk but bit 0 clear
        mem_tab[32'h0005_0000 + {18'h0, 12'h777, 2'b00}] = {22'h00_4444, 9'h1FF, 1'b0};
        walk(32'h7770_0000, 32'h0005_0000);
        chk(w_fault && !w_done, "R7", "fault raised", {30'h0, w_done, w_fault}, 32'h1);
        chk(w_lvl == 1'b0, "R7", "fault level", {31'h0, w_lvl}, 32'h0);
        chk(reads == 1, "R7", "single read", reads, 1);
    endtask

    task automatic t_inner_fault_r8();
        lat = 0;
        mem_tab[32'h0006_0000 + {18'h0, 12'h010, 2'b00}] = {22'h00_5000, 9'h0, 1'b1};
        walk(32'h0100_2000, 32'h0006_0000);
        chk(w_fault && !w_done, "R8", "fault raised", {30'h0, w_done, w_fault}, 32'h1);
        chk(w_lvl == 1'b1, "R8", "fault level", {31'h0, w_lvl}, 32'h1);
        chk(reads == 2, "R8", "two reads", reads, 2);
    endtask

    task automatic t_busy_r2();
        lat = 4;
        map(32'h2345_6789, 32'h0007_0000, 22'h00_0777, 22'h11_1111, 9'h0);
        @(negedge clk);
        reads = 0;
        req_valid = 1'b1; req_vaddr = 32'h2345_6789; base_reg = 32'h0007_0000;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R2", "busy not ready", {31'h0, req_ready}, 32'h0);
        req_valid = 1'b1; req_vaddr = 32'hFFFF_0000; base_reg = 32'h0000_0000;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_result();
        expect_ok("R2 busy request", 32'h2345_6789, 32'h0007_0000, 22'h00_0777, 22'h11_1111);
        chk(reads == 2, "R2", "no extra reads", reads, 2);
        repeat (20) @(negedge clk);
        chk(mem_req == 1'b0, "R2", "no later walk", {31'h0, mem_req}, 32'h0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_basic();
                t_slow();
                t_corner();
                t_junk_r6();
                t_outer_fault_r7();
                t_inner_fault_r8();
                t_busy_r2();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule